// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns raw external interrupt pins into interrupt-pending flags for a small processor's interrupt controller. There are `NUM_SRC` sources, two by default. Each raw pin first passes through a synchroniser chain. The block then looks for the programmed condition on the synchronised sample.

Two configuration bits choose the condition for each source. The mode bit picks edge or level detection. The polarity bit picks whether the active state is high or low. Together they give four detection types.

In edge mode, a detected active edge latches a pending flag. The flag stays set until one of two things happens:
- the interrupt controller pulses the source's vector acknowledge, or
- software writes the flag through a per-source write strobe and data bit.

In level mode, nothing is latched. The pending output is simply the synchronised active-level indicator. A request that is still asserted after service therefore raises the flag again at once. The block only observes the pin and never drives it.

Top module: `extint_conditioner`

## Requirements
- R1: While reset is asserted, and during the first `SYNC_STAGES` clock edges after reset is released, every `pend_o` bit is 0, whatever the pin or configuration. No edge is reported before `SYNC_STAGES+1` edges after reset.
- R2: `edge_mode_i` = 1 selects edge detection and 0 selects level detection. `act_high_i` = 1 makes high (rising) active and 0 makes low (falling) active. This gives four detection types.
- R3: The pin is sampled through `SYNC_STAGES` (default 2) flops. In level mode, `pend_o` after a clock edge shows the pin as sampled `SYNC_STAGES` edges earlier. In edge mode, the flag sets on the `SYNC_STAGES+1`-th edge after the pin makes its active transition.
- R4: In edge mode, a set flag holds while no acknowledge and no software write arrive, even after the pin goes inactive again.
- R5: In edge mode, `vec_ack_i` clears the flag on the next edge. If an active edge is detected in the same cycle as the acknowledge, the flag stays set.
- R6: In edge mode, a pulse on `sw_wr_i` loads `sw_wdata_i` into the flag. A detected active edge in the same cycle wins over a write of 0.
- R7: In level mode, `pend_o` is 1 exactly while the synchronised pin is at its active level. `vec_ack_i` and `sw_wr_i` have no effect, so a level still active after acknowledge keeps `pend_o` at 1.
- R8: Any cycle spent in level mode discards the edge flag. After switching back to edge mode, `pend_o` stays 0 until a new edge or a software write.
- R9: Sources are independent. Pins, configuration, acknowledges and writes of one source never change another source's `pend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_SRC | Raw, asynchronous interrupt pins |
| edge_mode_i | input | NUM_SRC | 1 = edge detection, 0 = level detection |
| act_high_i | input | NUM_SRC | 1 = active high / rising, 0 = active low / falling |
| vec_ack_i | input | NUM_SRC | One-cycle vector acknowledge per source |
| sw_wr_i | input | NUM_SRC | Software write strobe for the edge flag |
| sw_wdata_i | input | NUM_SRC | Value written to the edge flag |
| pend_o | output | NUM_SRC | Interrupt-pending flags |

## Verification
The bench aims an active edge at the exact cycle of an acknowledge, and at the exact cycle of a software clear. A design that lets the clear win would lose an interrupt that arrived during service.

It holds a level request active through an acknowledge and a software write. A design that latched or cleared level flags would drop a request that must be re-raised.

It drives pins in the first cycles after reset to catch reset-value samples read as edges or levels. It also toggles the mode while a flag is set, so an edge flag that outlives level mode shows up as a stale interrupt.

// File: rtl/extint_pkg.sv
package extint_pkg;

   // Detection type formed as {mode bit, polarity bit}
   typedef enum logic [1:0] {
      DET_LOW_LEVEL  = 2'b00,
      DET_HIGH_LEVEL = 2'b01,
      DET_FALL_EDGE  = 2'b10,
      DET_RISE_EDGE  = 2'b11
   } det_kind_e;

   function automatic logic is_active(input logic sample, input logic act_high);
      return act_high ? sample : ~sample;
   endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic samp_o,
   output logic prev_o,
   output logic lvl_ok_o,
   output logic edge_ok_o
);
   localparam int WARM_W = STAGES + 1;

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic [WARM_W-1:0] warm_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("extint_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         warm_q <= '0;
      end else begin
         prev_q <= chain_q[STAGES-1];
         warm_q <= {warm_q[WARM_W-2:0], 1'b1};
      end
   end

   assign samp_o    = chain_q[STAGES-1];
   assign prev_o    = prev_q;
   assign lvl_ok_o  = warm_q[STAGES-1];
   assign edge_ok_o = warm_q[STAGES];

   AST_PREV_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (prev_o == $past(samp_o))); // R3
   AST_EDGE_AFTER_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_ok_o |-> lvl_ok_o); // R1

endmodule

// File: rtl/extint_flag.sv
module extint_flag
   import extint_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic edge_mode_i,
   input  logic act_high_i,
   input  logic samp_i,
   input  logic prev_i,
   input  logic lvl_ok_i,
   input  logic edge_ok_i,
   input  logic ack_i,
   input  logic sw_wr_i,
   input  logic sw_wdata_i,
   output logic pend_o
);
   det_kind_e kind;
   logic      lvl_hit;
   logic      edge_hit;
   logic      flag_q;
   logic      flag_d;

   always_comb begin
      kind     = det_kind_e'({edge_mode_i, act_high_i});
      lvl_hit  = 1'b0;
      edge_hit = 1'b0;
      case (kind)
         DET_LOW_LEVEL:  lvl_hit  = is_active(samp_i, 1'b0);
         DET_HIGH_LEVEL: lvl_hit  = is_active(samp_i, 1'b1);
         DET_FALL_EDGE:  edge_hit = edge_ok_i & ~samp_i & prev_i;
         DET_RISE_EDGE:  edge_hit = edge_ok_i & samp_i & ~prev_i;
         default: begin
            lvl_hit  = 1'b0;
            edge_hit = 1'b0;
         end
      endcase
   end

   always_comb begin
      if (!edge_mode_i)  flag_d = 1'b0;
      else if (edge_hit) flag_d = 1'b1;
      else if (sw_wr_i)  flag_d = sw_wdata_i;
      else if (ack_i)    flag_d = 1'b0;
      else               flag_d = flag_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_d;
   end

   assign pend_o = edge_mode_i ? flag_q : (lvl_ok_i & lvl_hit);

   AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && edge_hit) |=> flag_q); // R5
   AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && !edge_hit && !ack_i && !sw_wr_i) |=> $stable(flag_q)); // R4
   AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && ack_i && !edge_hit && !sw_wr_i) |=> !flag_q); // R5
   AST_SW_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && sw_wr_i && !edge_hit) |=> (flag_q == $past(sw_wdata_i))); // R6
   AST_LEVEL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !edge_mode_i |=> !flag_q); // R8
   AST_WARMUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lvl_ok_i |-> !pend_o); // R1

endmodule

// File: rtl/extint_conditioner.sv
module extint_conditioner #(
   parameter int NUM_SRC     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] pin_i,
   input  logic [NUM_SRC-1:0] edge_mode_i,
   input  logic [NUM_SRC-1:0] act_high_i,
   input  logic [NUM_SRC-1:0] vec_ack_i,
   input  logic [NUM_SRC-1:0] sw_wr_i,
   input  logic [NUM_SRC-1:0] sw_wdata_i,
   output logic [NUM_SRC-1:0] pend_o
);
   generate
      if (NUM_SRC < 1) begin : g_bad_num
         $error("extint_conditioner: NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] samp;
   logic [NUM_SRC-1:0] prev;
   logic [NUM_SRC-1:0] lvl_ok;
   logic [NUM_SRC-1:0] edge_ok;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .pin_i     (pin_i[i]),
            .samp_o    (samp[i]),
            .prev_o    (prev[i]),
            .lvl_ok_o  (lvl_ok[i]),
            .edge_ok_o (edge_ok[i])
         );
         extint_flag u_flag (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .edge_mode_i (edge_mode_i[i]),
            .act_high_i  (act_high_i[i]),
            .samp_i      (samp[i]),
            .prev_i      (prev[i]),
            .lvl_ok_i    (lvl_ok[i]),
            .edge_ok_i   (edge_ok[i]),
            .ack_i       (vec_ack_i[i]),
            .sw_wr_i     (sw_wr_i[i]),
            .sw_wdata_i  (sw_wdata_i[i]),
            .pend_o      (pend_o[i])
         );
      end
   endgenerate

   AST_LEVEL_IGNORES_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i == '0 && $past(edge_mode_i) == '0 && pin_i == $past(pin_i)
       && act_high_i == $past(act_high_i) && $past(vec_ack_i) != '0 && lvl_ok != '0
       && $stable(samp)) |-> $stable(pend_o)); // R7

endmodule

// File: tb/extint_conditioner_test.sv
module extint_conditioner_test;
   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin = '0, emode = '0, ahigh = '0, ack = '0, swr = '0, swd = '0;
   logic [N-1:0] pend;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   extint_conditioner #(.NUM_SRC(N), .SYNC_STAGES(2)) uut (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .edge_mode_i(emode),
      .act_high_i(ahigh), .vec_ack_i(ack), .sw_wr_i(swr), .sw_wdata_i(swd),
      .pend_o(pend)
   );

   // Reference model: history of pin samples and per-source edge flag
   logic h1 [N], h2 [N], h3 [N], mflag [N];
   int   age;

   function automatic logic act(input logic v, input logic hi);
      return hi ? v : !v;
   endfunction

   function automatic logic exp_pend(input int i);
      if (emode[i]) return mflag[i];
      return (age >= 2) && act(h2[i], ahigh[i]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         age <= 0;
         for (int i = 0; i < N; i++) begin
            h1[i] <= 1'b0; h2[i] <= 1'b0; h3[i] <= 1'b0; mflag[i] <= 1'b0;
         end
      end else begin
         age <= (age < 3) ? age + 1 : age;
         for (int i = 0; i < N; i++) begin
            logic edet;
            edet = (age >= 3) && act(h2[i], ahigh[i]) && !act(h3[i], ahigh[i]);
            if (!emode[i])    mflag[i] <= 1'b0;
            else if (edet)    mflag[i] <= 1'b1;
            else if (swr[i])  mflag[i] <= swd[i];
            else if (ack[i])  mflag[i] <= 1'b0;
            h3[i] <= h2[i]; h2[i] <= h1[i]; h1[i] <= pin[i];
         end
      end
   end

   task automatic check_all(input string tag);
      for (int i = 0; i < N; i++) begin
         logic e;
         e = rst_n ? exp_pend(i) : 1'b0;
         checks++;
         if (pend[i] !== e) begin
            fails++;
            $display("FAIL %s src%0d: pend=%b expected=%b at %0t", tag, i, pend[i], e, $time);
         end
      end
   endtask

   task automatic step(input string tag);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      pin = 2'b11; ahigh = 2'b11;
      repeat (3) @(posedge clk);
      step("R1 in reset");
      // R1: level mode, active low, pins at active level right at release
      pin = 2'b00; ahigh = 2'b00; emode = 2'b00;
      rst_n = 1'b1;
      step("R1 warm-up");
      step("R1 warm-up");
      step("R7 level active low");
      // R7: ack and software write ignored in level mode
      ack = 2'b11; swr = 2'b11; swd = 2'b00;
      step("R7 ack/write ignored");
      ack = '0; swr = '0;
      step("R7 level still active");
      // R3: pin goes inactive, pend follows after two edges
      pin = 2'b11;
      step("R3 sync delay 1");
      step("R3 sync delay 2");
      // R2: rising edge mode on src0, falling edge on src1
      emode = 2'b11; ahigh = 2'b01; pin = 2'b10;
      repeat (3) step("R2 edge setup");
      pin = 2'b01;
      step("R3 edge 1"); step("R3 edge 2"); step("R3 edge flag set");
      pin = 2'b10;
      repeat (4) step("R4 flag holds");
      // R9: acknowledge src0 only
      ack = 2'b01;
      step("R9 ack src0 only");
      ack = 2'b10;
      step("R5 ack clears");
      ack = '0;
      // R6: software set then clear
      swr = 2'b11; swd = 2'b11;
      step("R6 sw set");
      swd = 2'b00;
      step("R6 sw clear");
      swd = 2'b11;
      step("R6 sw set again");
      swr = '0;
      // R5: edge coincides with ack, flag stays set (src0 rising)
      pin = 2'b00; repeat (3) step("R5 prep");
      pin = 2'b01; step("R5 prep"); step("R5 prep");
      ack = 2'b01;
      step("R5 edge beats ack");
      ack = '0;
      // R6: edge coincides with a software clear (src1 falling)
      pin = 2'b10; repeat (3) step("R6 prep");
      pin = 2'b00; step("R6 prep"); step("R6 prep");
      swr = 2'b10; swd = 2'b00;
      step("R6 edge beats clear");
      swr = '0;
      // R8: one cycle in level mode (pins inactive) drops the flag
      pin = 2'b10; ahigh = 2'b01;
      repeat (3) step("R8 prep");
      emode = 2'b00;
      step("R8 level inactive");
      emode = 2'b11;
      step("R8 flag discarded");
      step("R8 flag discarded");
      // Random phase
      for (int n = 0; n < 4000; n++) begin
         for (int i = 0; i < N; i++) begin
            if ($urandom_range(0, 3) == 0) pin[i] = ~pin[i];
            if ($urandom_range(0, 40) == 0) emode[i] = ~emode[i];
            if ($urandom_range(0, 60) == 0) ahigh[i] = ~ahigh[i];
            ack[i] = ($urandom_range(0, 7) == 0);
            swr[i] = ($urandom_range(0, 11) == 0);
            swd[i] = $urandom_range(0, 1);
         end
         step("R4/R7/R9 random");
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule